// File: doc/BRIEF.md
# Low-Power Mode Controller

This block tracks whether a small 8-bit microcontroller core is running, idling or powered down. It decides which clocks run, how the strobe pins and the four 8-bit ports behave, and which events can wake the core. The core makes a mode request with a one-cycle strobe when it writes its power-control register. In idle the CPU clock stops and the oscillator keeps running. In power-down the oscillator stops as well. Register and RAM contents are never touched by this block; it only gates clocks and access.

An enabled interrupt ends idle. The hardware reset pin also ends idle, but the core first keeps running for two machine cycles. During that window this block blocks internal RAM access and leaves the ports writable. The reset pin is the only way out of power-down. It must be held for a programmable number of oscillator cycles, so the oscillator can settle, before the CPU clock comes back. Pin overrides depend on the mode and on whether code is fetched from external program memory.

Top module: `lpm_ctrl`

## Requirements
- R1: After power-on reset (`arst_n` low) the block is running: `cpu_clk_en`=1, `osc_en`=1, both flags 0, `ram_inhibit`=0, `ale_psen_force`=0, `port_hold`=0, `port0_float`=0. While running, `core_rst` equals `hw_rst`.
- R2: When running and `hw_rst` is low, a `req_idle` pulse with `req_pd` low gives, from the next cycle on, `idle_flag`=1, `cpu_clk_en`=0, `osc_en`=1, `ale_psen_force`=1 and `ale_psen_level`=1.
- R3: When running and `hw_rst` is low, a `req_pd` pulse gives, from the next cycle on, `pd_flag`=1, `osc_en`=0, `cpu_clk_en`=0, `ale_psen_force`=1 and `ale_psen_level`=0. `req_pd` wins when both requests are high.
- R4: In idle with `hw_rst` low, any single bit of `irq` set gives `cpu_clk_en`=1 and `idle_flag`=0 on the next cycle. With `irq` all zero, idle persists.
- R5: In power-down, `irq` and both request strobes have no effect: `osc_en` and `cpu_clk_en` stay 0 and `pd_flag` stays 1.
- R6: If `hw_rst` is seen high in idle (even when `irq` is also set), then for the next 2*`OSC_PER_MC` cycles: `cpu_clk_en`=1, `ram_inhibit`=1, `core_rst`=0, `idle_flag`=0, `port_hold`=0. After that the block is running and `core_rst` follows `hw_rst`.
- R7: In power-down, `hw_rst` turns `osc_en` on from the next cycle. `cpu_clk_en` becomes 1 only in the cycle after `hw_rst` has been sampled high for `STAB_CYC` consecutive cycles, and `pd_flag` then clears. If `hw_rst` drops earlier, the block returns to power-down with `osc_en`=0.
- R8: In either low-power state, `port_hold` bits 3..1 are 1. When `ext_code`=1, `port0_float`=1 and `port_hold[0]`=0. When `ext_code`=0, `port0_float`=0 and `port_hold[0]`=1.
- R9: Mode requests are ignored while `hw_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| hw_rst | input | 1 | Hardware reset pin, sampled synchronously |
| req_idle | input | 1 | Idle request strobe from the power-control write |
| req_pd | input | 1 | Power-down request strobe |
| irq | input | N_IRQ | Enabled interrupt requests |
| ext_code | input | 1 | 1 = program fetched from external memory |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator enable |
| ram_inhibit | output | 1 | Blocks internal RAM access |
| core_rst | output | 1 | Reset to the core |
| idle_flag | output | 1 | Idle mode flag |
| pd_flag | output | 1 | Power-down mode flag |
| ale_psen_force | output | 1 | Overrides the ALE and PSEN pins |
| ale_psen_level | output | 1 | Level forced onto ALE and PSEN |
| port_hold | output | 4 | Per-port freeze of output data |
| port0_float | output | 1 | Port 0 drivers tri-stated |

## Verification
The bench sweeps the reset hold length in power-down from one cycle to one past `STAB_CYC`. A counter that is off by one would either enable the CPU clock one cycle early or leave the oscillator running after an early release. Every idle wake is tried from every interrupt bit, with both program-memory selects, so a reduced OR or a swapped port-0 rule shows up. The reset-from-idle window is measured cycle by cycle, including a collision with an interrupt. A design that let the interrupt win, sized the window wrongly, or asserted core reset inside it would report wrong `ram_inhibit` or `core_rst` values.

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int N_IRQ      = 5,
  parameter int OSC_PER_MC = 12,
  parameter int STAB_CYC   = 16
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             hw_rst,
  input  logic             req_idle,
  input  logic             req_pd,
  input  logic [N_IRQ-1:0] irq,
  input  logic             ext_code,
  output logic             cpu_clk_en,
  output logic             osc_en,
  output logic             ram_inhibit,
  output logic             core_rst,
  output logic             idle_flag,
  output logic             pd_flag,
  output logic             ale_psen_force,
  output logic             ale_psen_level,
  output logic [3:0]       port_hold,
  output logic             port0_float
);
  localparam int WIN  = 2 * OSC_PER_MC;
  localparam int CMAX = (WIN > STAB_CYC) ? WIN : STAB_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] WIN_LAST  = CW'(WIN - 1);
  localparam logic [CW-1:0] STAB_LAST = CW'(STAB_CYC - 1);

  typedef enum logic [2:0] {S_RUN, S_IDLE, S_IWIN, S_PD, S_STAB} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          lp;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st  <= S_RUN;
      cnt <= '0;
    end else begin
      case (st)
        S_RUN:
          if (!hw_rst) begin
            if (req_pd)        st <= S_PD;
            else if (req_idle) st <= S_IDLE;
          end
        S_IDLE:
          if (hw_rst) begin
            st  <= S_IWIN;
            cnt <= '0;
          end else if (|irq) begin
            st <= S_RUN;
          end
        S_IWIN:
          if (cnt == WIN_LAST) st <= S_RUN;
          else                 cnt <= cnt + 1'b1;
        S_PD:
          if (hw_rst) begin
            st  <= S_STAB;
            cnt <= CW'(1);
          end
        S_STAB:
          if (!hw_rst)                st <= S_PD;
          else if (cnt == STAB_LAST)  st <= S_RUN;
          else                        cnt <= cnt + 1'b1;
        default: st <= S_RUN;
      endcase
    end
  end

  assign lp             = (st == S_IDLE) || (st == S_PD) || (st == S_STAB);
  assign cpu_clk_en     = (st == S_RUN) || (st == S_IWIN);
  assign osc_en         = (st != S_PD);
  assign ram_inhibit    = (st == S_IWIN);
  assign core_rst       = hw_rst && ((st == S_RUN) || (st == S_STAB));
  assign idle_flag      = (st == S_IDLE);
  assign pd_flag        = (st == S_PD) || (st == S_STAB);
  assign ale_psen_force = lp;
  assign ale_psen_level = (st == S_IDLE);
  assign port0_float    = lp && ext_code;
  assign port_hold      = {{3{lp}}, lp && !ext_code};
endmodule

module lpm_ctrl_chk #(
  parameter int N_IRQ = 5
) (
  input logic             clk,
  input logic             arst_n,
  input logic             hw_rst,
  input logic             req_idle,
  input logic             req_pd,
  input logic [N_IRQ-1:0] irq,
  input logic             ext_code,
  input logic             cpu_clk_en,
  input logic             osc_en,
  input logic             ram_inhibit,
  input logic             core_rst,
  input logic             idle_flag,
  input logic             pd_flag,
  input logic             ale_psen_force,
  input logic             ale_psen_level,
  input logic [3:0]       port_hold,
  input logic             port0_float
);
  logic running;
  assign running = !idle_flag && !pd_flag && !ram_inhibit;

  // R2
  idle_entry_chk: assert property (@(posedge clk) disable iff (!arst_n)
    running && !hw_rst && req_idle && !req_pd |=> idle_flag && !cpu_clk_en && ale_psen_level);

  // R3
  pd_entry_chk: assert property (@(posedge clk) disable iff (!arst_n)
    running && !hw_rst && req_pd |=> pd_flag && !osc_en && !ale_psen_level);

  // R3
  osc_gate_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !osc_en |-> !cpu_clk_en);

  // R4
  idle_wake_chk: assert property (@(posedge clk) disable iff (!arst_n)
    idle_flag && !hw_rst && (|irq) |=> cpu_clk_en && !idle_flag);

  // R5
  pd_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    pd_flag && !hw_rst |=> pd_flag && !cpu_clk_en);

  // R6
  win_start_chk: assert property (@(posedge clk) disable iff (!arst_n)
    idle_flag && hw_rst |=> ram_inhibit && cpu_clk_en);

  // R6
  win_shape_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ram_inhibit |-> cpu_clk_en && !core_rst && !idle_flag && (port_hold == 4'b0000));

  // R7
  pd_exit_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(pd_flag) |-> $past(hw_rst) && cpu_clk_en);

  // R8
  float_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ale_psen_force |-> (port0_float == ext_code) && (port_hold[0] == !ext_code) && (port_hold[3:1] == 3'b111));

  // R9
  rst_req_chk: assert property (@(posedge clk) disable iff (!arst_n)
    running && hw_rst && (req_idle || req_pd) |=> running);
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.N_IRQ(N_IRQ)) chk_i (.*);

// File: tb/lpm_ctrl_tb_top.sv
module lpm_ctrl_tb_top;
  localparam int N_IRQ = 3;
  localparam int OSC_PER_MC = 2;
  localparam int STAB_CYC = 5;
  localparam int WIN = 2 * OSC_PER_MC;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic hw_rst = 1'b0, req_idle = 1'b0, req_pd = 1'b0, ext_code = 1'b0;
  logic [N_IRQ-1:0] irq = '0;
  logic cpu_clk_en, osc_en, ram_inhibit, core_rst, idle_flag, pd_flag;
  logic ale_psen_force, ale_psen_level, port0_float;
  logic [3:0] port_hold;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  lpm_ctrl #(.N_IRQ(N_IRQ), .OSC_PER_MC(OSC_PER_MC), .STAB_CYC(STAB_CYC)) dut_i (
    .clk(clk), .arst_n(arst_n), .hw_rst(hw_rst), .req_idle(req_idle), .req_pd(req_pd),
    .irq(irq), .ext_code(ext_code), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
    .ram_inhibit(ram_inhibit), .core_rst(core_rst), .idle_flag(idle_flag),
    .pd_flag(pd_flag), .ale_psen_force(ale_psen_force), .ale_psen_level(ale_psen_level),
    .port_hold(port_hold), .port0_float(port0_float));

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk_lp(string req, bit idle, bit ext);
    chk(req, "idle_flag", idle_flag, idle);
    chk(req, "pd_flag", pd_flag, !idle);
    chk(req, "cpu_clk_en", cpu_clk_en, 0);
    chk(req, "osc_en", osc_en, idle);
    chk(req, "force", ale_psen_force, 1);
    chk(req, "level", ale_psen_level, idle);
    chk("R8", "port_hold", port_hold, ext ? 4'b1110 : 4'b1111);
    chk("R8", "port0_float", port0_float, ext);
  endtask

  task automatic chk_run(string req);
    chk(req, "cpu_clk_en", cpu_clk_en, 1);
    chk(req, "osc_en", osc_en, 1);
    chk(req, "flags", {idle_flag, pd_flag}, 0);
    chk(req, "ram_inhibit", ram_inhibit, 0);
    chk(req, "port_hold", port_hold, 0);
    chk(req, "force", ale_psen_force, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step();
    chk_run("R1");
    chk("R1", "port0_float", port0_float, 0);
    arst_n = 1'b1;
    step();
    chk_run("R1");

    // R1 / R9: core reset follows pin while running, requests ignored
    hw_rst = 1'b1; req_idle = 1'b1; req_pd = 1'b1;
    #1 chk("R1", "core_rst", core_rst, 1);
    step();
    req_idle = 1'b0; req_pd = 1'b0;
    chk_run("R9");
    hw_rst = 1'b0;
    #1 chk("R1", "core_rst", core_rst, 0);
    step();

    // R2 / R4 / R8: idle entry and wake per irq bit and memory select
    for (int e = 0; e < 2; e++) begin
      for (int b = 0; b < N_IRQ; b++) begin
        ext_code = e[0];
        req_idle = 1'b1;
        step();
        req_idle = 1'b0;
        chk_lp("R2", 1, e[0]);
        repeat (3) step();
        chk_lp("R4", 1, e[0]);
        irq = N_IRQ'(1) << b;
        step();
        irq = '0;
        chk_run("R4");
      end
    end

    // R3 / R5: power-down priority and deafness
    for (int e = 0; e < 2; e++) begin
      ext_code = e[0];
      req_idle = 1'b1; req_pd = 1'b1;
      step();
      chk_lp("R3", 0, e[0]);
      irq = '1;
      repeat (4) step();
      chk_lp("R5", 0, e[0]);
      req_idle = 1'b0; req_pd = 1'b0; irq = '0;
      // R7: sweep reset hold length
      for (int len = 1; len <= STAB_CYC + 1; len++) begin
        hw_rst = 1'b1;
        for (int k = 1; k <= len; k++) begin
          step();
          chk("R7", "osc_en", osc_en, 1);
          chk("R7", "cpu_clk_en", cpu_clk_en, (k >= STAB_CYC) ? 1 : 0);
          chk("R7", "pd_flag", pd_flag, (k >= STAB_CYC) ? 0 : 1);
        end
        hw_rst = 1'b0;
        step();
        if (len < STAB_CYC) begin
          chk_lp("R7", 0, e[0]);
        end else begin
          chk_run("R7");
          chk("R7", "core_rst", core_rst, 0);
          req_pd = 1'b1;
          step();
          req_pd = 1'b0;
          chk_lp("R3", 0, e[0]);
        end
      end
      hw_rst = 1'b1;
      repeat (STAB_CYC) step();
      hw_rst = 1'b0;
      step();
      chk_run("R7");
    end

    // R6: reset ending idle, with and without a colliding interrupt
    for (int e = 0; e < 2; e++) begin
      for (int c = 0; c < 2; c++) begin
        ext_code = e[0];
        req_idle = 1'b1;
        step();
        req_idle = 1'b0;
        chk_lp("R2", 1, e[0]);
        hw_rst = 1'b1;
        irq = c[0] ? '1 : '0;
        for (int k = 1; k <= WIN; k++) begin
          step();
          irq = '0;
          chk("R6", "ram_inhibit", ram_inhibit, 1);
          chk("R6", "cpu_clk_en", cpu_clk_en, 1);
          chk("R6", "core_rst", core_rst, 0);
          chk("R6", "idle_flag", idle_flag, 0);
          chk("R6", "port_hold", port_hold, 0);
        end
        step();
        chk("R6", "ram_inhibit end", ram_inhibit, 0);
        chk("R6", "core_rst end", core_rst, 1);
        chk("R6", "cpu_clk_en end", cpu_clk_en, 1);
        hw_rst = 1'b0;
        step();
        chk_run("R6");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule